// File: doc/BRIEF.md
# Host Clock and Interrupt Controller

This block sits next to the protocol logic of a low-power radio receiver. It derives the clock for an external host microcontroller from the crystal clock. The divide ratio is either four or six, and the receive-band setting picks it. The block also drives two status lines toward the host. The wake line is high while a reception is in progress. The interrupt line carries short pulses, and the host tells the two kinds of pulse apart only by the level of the wake line at that moment.

The protocol logic reports three things. A pulse on `rx_hit` marks useful data on the air. A pulse on `msg_done` marks a fully decoded message. A pulse on `clk_req` marks the start of a detection phase, and it switches the host clock on. The block declares the transmission stopped after a programmable number of timing ticks with no useful data. When the resulting end interrupt has finished, the block lets the host clock run for a fixed number of further periods and then gates it off. The gate only ever switches inside a low phase, so no shortened high phase reaches the host.

Top module: `hc_host_clk_irq`

## Requirements
- R1: While reset is held and directly after it, `host_clk`, `wake_o` and `irq_o` are all low.
- R2: With `band_sel` = 2'b10 the host clock period is DIV_SLOW (6) crystal cycles, high for 3 and low for 3. Every other code (2'b00, 2'b01, 2'b11) gives DIV_FAST (4) cycles, high for 2 and low for 2.
- R3: A change of `band_sel` takes effect only at a period boundary, so in every host clock period the high and low phases have the same length.
- R4: A `clk_req` pulse enables the host clock. Enabling and disabling change the gate only during a low phase, so every high phase seen at `host_clk` is full length.
- R5: An `rx_hit` pulse while `wake_o` is low drives `wake_o` high on the following clock edge.
- R6: The first `msg_done` after `wake_o` rises drives `irq_o` high while `wake_o` stays high. The pulse lasts exactly PULSE_TICKS (5) `tick` pulses. Further `msg_done` pulses during the same wake period raise no interrupt.
- R7: A `msg_done` pulse while `wake_o` is low has no effect on `irq_o`.
- R8: After STOP_TICKS (300) `tick` pulses with no `rx_hit`, `wake_o` falls and `irq_o` rises on the same edge, and that pulse lasts PULSE_TICKS ticks. Each `rx_hit` restarts the count.
- R9: After the falling edge of an interrupt pulse that ends with `wake_o` low, `host_clk` shows exactly HOLD_CYCLES (16) rising edges and then stays low. A `clk_req` during that countdown cancels the shutdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_xtal | input | 1 | Crystal clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| band_sel | input | 2 | Receive band code; 2'b10 selects the slow divider |
| tick | input | 1 | One-cycle timing tick for pulse width and stop timeout |
| clk_req | input | 1 | One-cycle request to start the host clock |
| rx_hit | input | 1 | One-cycle mark of useful received data |
| msg_done | input | 1 | One-cycle mark of a complete message |
| host_clk | output | 1 | Gated, divided clock for the host |
| wake_o | output | 1 | High while a reception is in progress |
| irq_o | output | 1 | Interrupt pulse; its meaning is read from `wake_o` |

## Verification
The bench changes the band code partway through a period. A divider that reloads its ratio at once would produce a period whose high and low phases differ in length. A running monitor checks every high phase against its low phase, and it also catches gating that cuts a high phase short. The shutdown count is checked exactly. A controller that starts counting one period early or one period late gives the host 15 or 17 rising edges instead of 16. The bench also checks that a second completed message, or a message reported while asleep, leaves the interrupt line low. It checks that the stop timer gives up only on its 300th tick after data was last seen, and only after an `rx_hit` part-way through the count has restarted it.

// File: rtl/hc_pkg.sv
package hc_pkg;

  typedef enum logic [1:0] {
    BAND_HI    = 2'b00,
    BAND_MID   = 2'b01,
    BAND_LO    = 2'b10,
    BAND_SPARE = 2'b11
  } band_e;

  // Only the lowest band runs the crystal on the slow-divide setting.
  function automatic logic f_slow_xtal(input logic [1:0] band);
    return band == BAND_LO;
  endfunction

  function automatic int unsigned f_period(input logic [1:0] band,
                                           input int unsigned fast_div,
                                           input int unsigned slow_div);
    return f_slow_xtal(band) ? slow_div : fast_div;
  endfunction

  function automatic int unsigned f_high_len(input int unsigned period);
    return period / 2;
  endfunction

endpackage

// File: rtl/hc_clkdiv.sv
module hc_clkdiv
  import hc_pkg::*;
#(
  parameter int unsigned DIV_FAST = 4,
  parameter int unsigned DIV_SLOW = 6,
  parameter int unsigned CW       = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] band,
  output logic       div_hi,
  output logic       per_last,
  output logic       gate_slot
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] len_q;
  logic [CW-1:0] half;
  logic [CW-1:0] next_len;

  assign half      = CW'(f_high_len(int'(len_q)));
  assign next_len  = CW'(f_period(band, DIV_FAST, DIV_SLOW));
  assign div_hi    = cnt_q < half;
  assign per_last  = cnt_q == (len_q - 1'b1);
  // First low cycle: the gate may switch here and stay hidden.
  assign gate_slot = cnt_q == half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= CW'(DIV_FAST);
    end else if (per_last) begin
      cnt_q <= '0;
      len_q <= next_len;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < len_q);

  // R3
  len_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q != $past(len_q)) |-> ($past(per_last) && cnt_q == '0));

endmodule

// File: rtl/hc_events.sv
module hc_events #(
  parameter int unsigned PULSE_TICKS = 5,
  parameter int unsigned STOP_TICKS  = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx_hit,
  input  logic msg_done,
  output logic wake_q,
  output logic irq_q
);

  localparam int unsigned PW = $clog2(PULSE_TICKS + 1);
  localparam int unsigned SW = $clog2(STOP_TICKS + 1);

  logic [PW-1:0] pcnt_q;
  logic [SW-1:0] icnt_q;
  logic          msg_seen_q;

  logic stop_evt;
  logic msg_evt;
  logic pulse_end;

  assign stop_evt  = wake_q && !rx_hit && tick && (icnt_q == SW'(STOP_TICKS - 1));
  assign msg_evt   = wake_q && msg_done && !msg_seen_q && !stop_evt;
  assign pulse_end = irq_q && tick && (pcnt_q == PW'(PULSE_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q     <= 1'b0;
      icnt_q     <= '0;
      msg_seen_q <= 1'b0;
    end else begin
      if (!wake_q) begin
        if (rx_hit) begin
          wake_q     <= 1'b1;
          icnt_q     <= '0;
          msg_seen_q <= 1'b0;
        end
      end else if (stop_evt) begin
        wake_q <= 1'b0;
      end else if (rx_hit) begin
        icnt_q <= '0;
      end else if (tick) begin
        icnt_q <= icnt_q + 1'b1;
      end
      if (msg_evt) msg_seen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      pcnt_q <= '0;
    end else if (stop_evt || msg_evt) begin
      irq_q  <= 1'b1;
      pcnt_q <= '0;
    end else if (pulse_end) begin
      irq_q <= 1'b0;
    end else if (irq_q && tick) begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end

  // R5
  wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_q) |-> $past(rx_hit));

  // R8
  stop_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_q) |-> irq_q);

  // R6
  msg_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q && msg_seen_q && !irq_q) |=> (!irq_q || !wake_q));

  // R7
  asleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_q && !irq_q) |=> !irq_q);

  // R6
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q < PW'(PULSE_TICKS));

endmodule

// File: rtl/hc_gate.sv
module hc_gate #(
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_req,
  input  logic wake,
  input  logic irq,
  input  logic div_hi,
  input  logic per_last,
  input  logic gate_slot,
  output logic host_clk
);

  localparam int unsigned HW = $clog2(HOLD_CYCLES + 1);

  logic          irq_d_q;
  logic          sd_act_q;
  logic [HW-1:0] sd_cnt_q;
  logic          want_q;
  logic          gate_q;
  logic          end_fall;
  logic          sd_run;

  // Falling edge of an interrupt that ends with the wake line low.
  assign end_fall = irq_d_q && !irq && !wake;
  assign sd_run   = sd_act_q || end_fall;
  assign host_clk = div_hi && gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_d_q  <= 1'b0;
      sd_act_q <= 1'b0;
      sd_cnt_q <= '0;
      want_q   <= 1'b0;
      gate_q   <= 1'b0;
    end else begin
      irq_d_q <= irq;
      if (clk_req) begin
        want_q   <= 1'b1;
        sd_act_q <= 1'b0;
        sd_cnt_q <= '0;
      end else if (sd_run) begin
        sd_act_q <= 1'b1;
        if (per_last) begin
          if (sd_cnt_q == HW'(HOLD_CYCLES - 1)) begin
            want_q   <= 1'b0;
            sd_act_q <= 1'b0;
            sd_cnt_q <= '0;
          end else begin
            sd_cnt_q <= sd_cnt_q + 1'b1;
          end
        end
      end
      if (gate_slot) gate_q <= want_q;
    end
  end

  // R4
  gate_glitch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q != $past(gate_q)) |-> (!div_hi && !$past(div_hi)));

  // R9
  hold_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cnt_q < HW'(HOLD_CYCLES));

  // R4
  gate_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> $past(want_q));

endmodule

// File: rtl/hc_host_clk_irq.sv
module hc_host_clk_irq #(
  parameter int unsigned DIV_FAST    = 4,
  parameter int unsigned DIV_SLOW    = 6,
  parameter int unsigned PULSE_TICKS = 5,
  parameter int unsigned STOP_TICKS  = 300,
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic       clk_xtal,
  input  logic       rst_n,
  input  logic [1:0] band_sel,
  input  logic       tick,
  input  logic       clk_req,
  input  logic       rx_hit,
  input  logic       msg_done,
  output logic       host_clk,
  output logic       wake_o,
  output logic       irq_o
);

  localparam int unsigned MAXD = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
  localparam int unsigned CW   = $clog2(MAXD + 1);

  logic div_hi;
  logic per_last;
  logic gate_slot;
  logic wake_w;
  logic irq_w;

  hc_clkdiv #(
    .DIV_FAST(DIV_FAST),
    .DIV_SLOW(DIV_SLOW),
    .CW      (CW)
  ) u_div (
    .clk      (clk_xtal),
    .rst_n    (rst_n),
    .band     (band_sel),
    .div_hi   (div_hi),
    .per_last (per_last),
    .gate_slot(gate_slot)
  );

  hc_events #(
    .PULSE_TICKS(PULSE_TICKS),
    .STOP_TICKS (STOP_TICKS)
  ) u_evt (
    .clk     (clk_xtal),
    .rst_n   (rst_n),
    .tick    (tick),
    .rx_hit  (rx_hit),
    .msg_done(msg_done),
    .wake_q  (wake_w),
    .irq_q   (irq_w)
  );

  hc_gate #(
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_gate (
    .clk      (clk_xtal),
    .rst_n    (rst_n),
    .clk_req  (clk_req),
    .wake     (wake_w),
    .irq      (irq_w),
    .div_hi   (div_hi),
    .per_last (per_last),
    .gate_slot(gate_slot),
    .host_clk (host_clk)
  );

  assign wake_o = wake_w;
  assign irq_o  = irq_w;

endmodule

// File: tb/test_hc_host_clk_irq.sv
module test_hc_host_clk_irq;

  localparam int PULSE = 5;
  localparam int STOP  = 300;
  localparam int HOLD  = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] band_sel = 2'b00;
  logic       tick = 1'b0;
  logic       clk_req = 1'b0;
  logic       rx_hit = 1'b0;
  logic       msg_done = 1'b0;
  logic       host_clk;
  logic       wake_o;
  logic       irq_o;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  hc_host_clk_irq i_hc_host_clk_irq (
    .clk_xtal(clk), .rst_n(rst_n), .band_sel(band_sel), .tick(tick),
    .clk_req(clk_req), .rx_hit(rx_hit), .msg_done(msg_done),
    .host_clk(host_clk), .wake_o(wake_o), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Phase monitor: every high phase full (R4), low phase equal to high (R3).
  bit mon_en = 0;
  bit prev_c = 0, seen_rise = 0, seen_fall = 0;
  int hi_run = 0, lo_run = 0, last_hi = 0;
  always @(negedge clk) begin
    if (!mon_en) begin
      seen_rise = 0; seen_fall = 0; prev_c = host_clk;
    end else begin
      if (host_clk) begin
        if (!prev_c) begin
          if (seen_fall && lo_run <= 3)
            check(lo_run == last_hi, "R3 low phase", lo_run, last_hi);
          seen_rise = 1; hi_run = 1;
        end else hi_run++;
      end else begin
        if (prev_c) begin
          if (seen_rise)
            check(hi_run == 2 || hi_run == 3, "R4 high phase", hi_run, 2);
          last_hi = hi_run; seen_fall = 1; lo_run = 1;
        end else if (lo_run < 1000) lo_run++;
      end
      prev_c = host_clk;
    end
  end

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask
  task automatic pulse_rx();
    @(negedge clk) rx_hit = 1'b1;
    @(negedge clk) rx_hit = 1'b0;
  endtask
  task automatic pulse_msg();
    @(negedge clk) msg_done = 1'b1;
    @(negedge clk) msg_done = 1'b0;
  endtask
  task automatic pulse_req();
    @(negedge clk) clk_req = 1'b1;
    @(negedge clk) clk_req = 1'b0;
  endtask

  // Measure one full period: wait for a rise, then count high and low samples.
  task automatic measure(output int hi, output int lo);
    hi = 0; lo = 0;
    @(negedge clk);
    while (host_clk) @(negedge clk);
    while (!host_clk) @(negedge clk);
    while (host_clk) begin hi++; @(negedge clk); end
    while (!host_clk) begin lo++; @(negedge clk); end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(host_clk == 0 && wake_o == 0 && irq_o == 0, "R1 in reset", {host_clk, wake_o, irq_o}, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (12) begin
      @(negedge clk);
      check(host_clk == 0 && wake_o == 0 && irq_o == 0, "R1 after reset", {host_clk, wake_o, irq_o}, 0);
    end
  endtask

  task automatic t_divider();
    int hi, lo;
    pulse_req();
    for (int b = 0; b < 4; b++) begin
      band_sel = 2'(b);
      measure(hi, lo);
      measure(hi, lo);
      check(hi == ((b == 2) ? 3 : 2), "R2 high len", hi, (b == 2) ? 3 : 2);
      check(lo == ((b == 2) ? 3 : 2), "R2 low len", lo, (b == 2) ? 3 : 2);
    end
  endtask

  task automatic t_switch();
    mon_en = 1;
    for (int k = 0; k < 12; k++) begin
      repeat (3 + (k % 5)) @(negedge clk);
      band_sel = (band_sel == 2'b10) ? 2'b01 : 2'b10;
    end
    repeat (20) @(negedge clk);
  endtask

  task automatic t_wake();
    pulse_rx();
    check(wake_o == 1, "R5 wake after rx_hit", wake_o, 1);
    check(irq_o == 0, "R5 no irq on wake", irq_o, 0);
  endtask

  task automatic t_msg();
    pulse_msg();
    check(irq_o == 1 && wake_o == 1, "R6 message irq", {irq_o, wake_o}, 3);
    for (int i = 0; i < PULSE - 1; i++) pulse_tick();
    check(irq_o == 1, "R6 pulse held", irq_o, 1);
    pulse_tick();
    check(irq_o == 0, "R6 pulse ends", irq_o, 0);
    pulse_msg();
    repeat (4) begin
      @(negedge clk);
      check(irq_o == 0, "R6 second message silent", irq_o, 0);
    end
  endtask

  task automatic run_to_stop(input string req);
    for (int i = 0; i < 100; i++) pulse_tick();
    pulse_rx();
    for (int i = 0; i < STOP - 1; i++) pulse_tick();
    check(wake_o == 1 && irq_o == 0, req, {wake_o, irq_o}, 2);
    pulse_tick();
    check(wake_o == 0 && irq_o == 1, req, {wake_o, irq_o}, 1);
    for (int i = 0; i < PULSE; i++) pulse_tick();
    check(irq_o == 0, req, irq_o, 0);
  endtask

  task automatic t_stop_shutdown();
    int rises;
    bit pv;
    band_sel = 2'b10;
    run_to_stop("R8 stop timeout");
    rises = 0;
    pv = host_clk;
    repeat (250) begin
      @(negedge clk);
      if (host_clk && !pv) rises++;
      pv = host_clk;
    end
    check(rises == HOLD, "R9 rises before stop", rises, HOLD);
    check(host_clk == 0, "R9 clock parked low", host_clk, 0);
  endtask

  task automatic t_asleep_msg();
    pulse_msg();
    repeat (5) begin
      @(negedge clk);
      check(irq_o == 0 && wake_o == 0, "R7 asleep message ignored", {irq_o, wake_o}, 0);
    end
  endtask

  task automatic t_cancel();
    int rises;
    bit pv;
    pulse_req();
    pulse_rx();
    run_to_stop("R8 second stop");
    repeat (30) @(negedge clk);
    pulse_req();
    repeat (300) @(negedge clk);
    rises = 0;
    pv = host_clk;
    repeat (60) begin
      @(negedge clk);
      if (host_clk && !pv) rises++;
      pv = host_clk;
    end
    check(rises == 10, "R9 cancel keeps clock", rises, 10);
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_divider();
    t_switch();
    t_wake();
    t_msg();
    t_stop_shutdown();
    mon_en = 0;
    t_asleep_msg();
    mon_en = 1;
    t_cancel();
    mon_en = 0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule